// File: doc/BRIEF.md
# Serial Bus Slave Engine with Stuck-Bus Timeout

This block is the slave side of a two-wire serial bus (I2C, with optional SMBus behaviour). A fast system clock samples the clock and data lines. Each line goes through a synchronizer and a short majority filter. The block then finds the start, repeated start and stop conditions, and shifts bytes in most-significant bit first. It compares the first byte of each transfer against a 7-bit device address and acknowledges or refuses each byte. Read data goes out through an open-drain style enable: a 1 on `sda_oe` pulls the data line low.

A memory controller sits behind the block on a plain parallel interface. Received bytes arrive as one-cycle `rx_valid` pulses. For reads the controller keeps the next byte ready on `rd_data`, and `rd_take` tells it when that byte has been consumed. While the controller raises `busy`, the slave refuses bytes with a NACK. The block never stretches the clock.

When `smbus_en` is set, a frozen bus is treated as a stop. The bus counts as frozen when, for `TMO_CYCLES` system clocks, the clock line makes no edge and the data line makes no rising edge, while a transfer is open or the data line is low.

Top module: `serbus_slave`

## Requirements
- R1: SDA falling while SCL is high gives a one-cycle `start_det`, whether or not a STOP came before it. SDA rising while SCL is high gives a one-cycle `stop_det`. The two never pulse in the same cycle.
- R2: The first byte after a START is taken MSB first. Bits [7:1] are the address and bit 0 is the direction, where 1 means read. If the address equals `dev_addr` and `busy` is low, the slave holds SDA low through the ninth clock, pulses `addr_hit` once, and sets `dir_rd` to the direction bit.
- R3: If the address byte does not match, the slave leaves SDA released on the ninth clock. It then ignores all clocks until the next START or STOP: no `rx_valid`, no `rd_take`, and no SDA drive.
- R4: In a write transfer, each data byte is taken MSB first. At the start of the ninth clock, `rx_valid` pulses for one cycle with the byte on `rx_data`, and the slave acknowledges that byte.
- R5: If `busy` is high when an acknowledge is decided (on the falling SCL edge after bit 8), the slave NACKs. A refused address gives no `addr_hit`, and a refused data byte gives no `rx_valid`.
- R6: In a read transfer, the slave takes `rd_data` when the address acknowledge clock falls, pulses `rd_take`, and drives the byte MSB first. Each bit changes only after a falling SCL edge.
- R7: If the master ACKs a read byte, the next `rd_data` byte is taken in the same way. If the master NACKs, the slave keeps SDA released until the next START or STOP.
- R8: A START in the middle of a byte drops the partial byte without `rx_valid` or `stop_det`. The next byte is then treated as an address byte.
- R9: With `smbus_en`=1 and a transfer open, if there is no SCL edge and no SDA rise for `TMO_CYCLES` clocks, `tmo_det` pulses once. The slave then returns to idle as after a STOP, so later clocks without a START are ignored.
- R10: With `smbus_en`=0, `tmo_det` stays low however long the bus is held, and an open transfer goes on when clocking resumes.
- R11: During reset and after it, `sda_oe`, `rx_valid`, `rd_take`, `addr_hit`, `dir_rd` and `tmo_det` are 0.
- R12: `sda_oe` only goes from 0 to 1 while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_addr | input | 7 | Address this slave answers to |
| smbus_en | input | 1 | Enables the stuck-bus timeout |
| busy | input | 1 | Refuse (NACK) bytes while high |
| start_det | output | 1 | START or repeated START seen |
| stop_det | output | 1 | STOP seen |
| tmo_det | output | 1 | Stuck-bus timeout fired |
| addr_hit | output | 1 | Address matched and acknowledged |
| dir_rd | output | 1 | Direction of the current selected transfer |
| rx_valid | output | 1 | Received data byte valid |
| rx_data | output | 8 | Received data byte |
| rd_data | input | 8 | Next byte to return to the master |
| rd_take | output | 1 | `rd_data` has been consumed |

## Verification
The bench builds the block with `TMO_CYCLES`=300 and keeps the default two-stage synchronizer and three-tap filter. Its modelled master runs a bit time of 40 system clocks, so SCL edges come every 20 clocks. Normal traffic therefore never comes near the window, while holding SCL low for 400 clocks goes clearly past it. This puts both the firing and the non-firing timeout cases within a short run. The 20-clock SCL half-periods also leave room for the filter latency, so every slave SDA change lands while SCL is low.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_END,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_LAST,
    ST_RD_ACK,
    ST_WAIT
  } sb_state_e;

  // Address byte: bits [7:1] compared with the device address.
  function automatic logic f_addr_match(input logic [7:0] abyte, input logic [6:0] dev);
    return abyte[7:1] == dev;
  endfunction

  // Direction bit of the address byte: 1 = master reads.
  function automatic logic f_is_read(input logic [7:0] abyte);
    return abyte[0];
  endfunction

  // Shift one received bit in at the LSB end.
  function automatic logic [7:0] f_shift_in(input logic [7:0] cur, input logic bit_in);
    return {cur[6:0], bit_in};
  endfunction

  // Open-drain enable needed to present a given data bit.
  function automatic logic f_drive_for(input logic data_bit);
    return ~data_bit;
  endfunction

endpackage

// File: rtl/sb_pin_filter.sv
module sb_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  localparam int HALF = TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        win_q;
  logic                   out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      out_q  <= ($countones(win_q) > HALF);
    end
  end

  assign pin_o = out_q;
endmodule

// File: rtl/sb_bus_events.sv
module sb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_rise,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign sda_rise  = sda_f & ~sda_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/sb_timeout.sv
module sb_timeout #(
  parameter int TMO_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic active,
  input  logic sda_lvl,
  input  logic kick,
  output logic hit
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          hit_q;
  logic          armed;

  // The window only runs while a transfer is open or SDA is held low.
  assign armed = enable & (active | ~sda_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (!armed || kick) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      hit_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      hit_q <= 1'b0;
    end
  end

  assign hit = hit_q;
endmodule

// File: rtl/sb_byte_engine.sv
module sb_byte_engine
  import sb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       tmo_evt,
  input  logic [6:0] dev_addr,
  input  logic       busy,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       addr_hit,
  output logic       dir_rd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rd_take,
  output logic       active
);
  sb_state_e  state_q;
  logic [2:0] bitcnt_q;
  logic [7:0] shreg_q;
  logic       mack_q;

  assign active = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
      addr_hit <= 1'b0;
      dir_rd   <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rd_take  <= 1'b0;
    end else begin
      addr_hit <= 1'b0;
      rx_valid <= 1'b0;
      rd_take  <= 1'b0;
      if (start_evt) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        sda_oe   <= 1'b0;
      end else if (stop_evt || tmo_evt) begin
        state_q  <= ST_IDLE;
        sda_oe   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise) begin
              shreg_q <= f_shift_in(shreg_q, sda_lvl);
              if (bitcnt_q == 3'd7) begin
                bitcnt_q <= '0;
                state_q  <= (state_q == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
              end else begin
                bitcnt_q <= bitcnt_q + 3'd1;
              end
            end
          end
          ST_ADDR_END: begin
            if (scl_fall) begin
              if (f_addr_match(shreg_q, dev_addr) && !busy) begin
                sda_oe   <= 1'b1;
                addr_hit <= 1'b1;
                dir_rd   <= f_is_read(shreg_q);
                state_q  <= ST_ADDR_ACK;
              end else begin
                state_q  <= ST_WAIT;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (dir_rd) begin
                shreg_q <= rd_data;
                sda_oe  <= f_drive_for(rd_data[7]);
                rd_take <= 1'b1;
                state_q <= ST_RD_DATA;
              end else begin
                sda_oe  <= 1'b0;
                state_q <= ST_WR_DATA;
              end
            end
          end
          ST_WR_END: begin
            if (scl_fall) begin
              sda_oe   <= ~busy;
              rx_valid <= ~busy;
              rx_data  <= shreg_q;
              state_q  <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              state_q <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_rise) begin
              if (bitcnt_q == 3'd7) begin
                bitcnt_q <= '0;
                state_q  <= ST_RD_LAST;
              end else begin
                bitcnt_q <= bitcnt_q + 3'd1;
              end
            end else if (scl_fall) begin
              shreg_q <= {shreg_q[6:0], 1'b0};
              sda_oe  <= f_drive_for(shreg_q[6]);
            end
          end
          ST_RD_LAST: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              state_q <= ST_RD_ACK;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                shreg_q  <= rd_data;
                sda_oe   <= f_drive_for(rd_data[7]);
                rd_take  <= 1'b1;
                bitcnt_q <= '0;
                state_q  <= ST_RD_DATA;
              end else begin
                state_q  <= ST_WAIT;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/serbus_slave.sv
module serbus_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3,
  parameter int TMO_CYCLES  = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [6:0] dev_addr,
  input  logic       smbus_en,
  input  logic       busy,
  output logic       start_det,
  output logic       stop_det,
  output logic       tmo_det,
  output logic       addr_hit,
  output logic       dir_rd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  input  logic [7:0] rd_data,
  output logic       rd_take
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] raw_pins;
  logic [NPINS-1:0] filt_pins;
  logic scl_lvl, sda_lvl;
  logic scl_rise, scl_fall, sda_rise;
  logic start_evt, stop_evt, tmo_evt;
  logic xfer_active;
  logic tmo_kick;

  assign raw_pins = {scl_i, sda_i};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    sb_pin_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILT_TAPS)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .pin_i(raw_pins[g]),
      .pin_o(filt_pins[g])
    );
  end

  assign scl_lvl = filt_pins[1];
  assign sda_lvl = filt_pins[0];

  sb_bus_events u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_lvl),
    .sda_f    (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_rise (sda_rise),
    .start_evt(start_evt),
    .stop_evt (stop_evt)
  );

  assign tmo_kick = scl_rise | scl_fall | sda_rise;

  sb_timeout #(
    .TMO_CYCLES(TMO_CYCLES)
  ) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (smbus_en),
    .active (xfer_active),
    .sda_lvl(sda_lvl),
    .kick   (tmo_kick),
    .hit    (tmo_evt)
  );

  sb_byte_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .tmo_evt  (tmo_evt),
    .dev_addr (dev_addr),
    .busy     (busy),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .addr_hit (addr_hit),
    .dir_rd   (dir_rd),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rd_take  (rd_take),
    .active   (xfer_active)
  );

  assign start_det = start_evt;
  assign stop_det  = stop_evt;
  assign tmo_det   = tmo_evt;
endmodule

// File: rtl/serbus_slave_chk.sv
module serbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe,
  input logic       smbus_en,
  input logic       busy,
  input logic       start_det,
  input logic       stop_det,
  input logic       tmo_det,
  input logic       addr_hit,
  input logic       rx_valid,
  input logic       rd_take,
  input logic [7:0] rd_data
);
  p_evt_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det}));

  // R2: an acknowledged address always has SDA pulled low.
  p_hit_drives_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (sda_oe && !$past(busy)));

  p_rx_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(busy));

  p_take_first_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |-> (sda_oe == !$past(rd_data[7])));

  p_rx_take_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rd_take));

  p_tmo_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_det |=> !sda_oe);

  p_no_tmo_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smbus_en) |-> !tmo_det);

  p_oe_rise_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);
endmodule

bind serbus_slave serbus_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .sda_oe   (sda_oe),
  .smbus_en (smbus_en),
  .busy     (busy),
  .start_det(start_det),
  .stop_det (stop_det),
  .tmo_det  (tmo_det),
  .addr_hit (addr_hit),
  .rx_valid (rx_valid),
  .rd_take  (rd_take),
  .rd_data  (rd_data)
);

// File: tb/serbus_slave_tb.sv
module serbus_slave_tb;
  localparam int TMO = 300;
  localparam int Q   = 10;
  localparam logic [6:0] DEV = 7'h53;
  // {addr7, data8, busy_at_addr, busy_at_data, exp_addr_ack, exp_data_ack}
  localparam logic [18:0] VEC [0:6] = '{
    {7'h53, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'h53, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'h53, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'h52, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0},
    {7'h53, 8'h81, 1'b0, 1'b1, 1'b1, 1'b0},
    {7'h53, 8'h7E, 1'b1, 1'b0, 1'b0, 1'b0},
    {7'h13, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic smbus_en = 1'b1, busy = 1'b0;
  logic sda_oe, start_det, stop_det, tmo_det, addr_hit, dir_rd, rx_valid, rd_take;
  logic [7:0] rx_data, rd_ptr = 8'd0, last_rx = 8'd0;
  logic [7:0] rd_data_b;
  logic sda_line;
  int n_rx = 0, n_take = 0, n_tmo = 0, n_stop = 0, n_start = 0, n_hit = 0;
  logic watch_en = 1'b0, oe_seen = 1'b0;
  int checks = 0, errs = 0;

  always #5 clk = ~clk;

  assign sda_line  = m_sda & ~sda_oe;
  assign rd_data_b = 8'hA5 ^ rd_ptr;

  serbus_slave #(.TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .dev_addr(DEV), .smbus_en(smbus_en), .busy(busy), .start_det(start_det),
    .stop_det(stop_det), .tmo_det(tmo_det), .addr_hit(addr_hit), .dir_rd(dir_rd),
    .rx_valid(rx_valid), .rx_data(rx_data), .rd_data(rd_data_b), .rd_take(rd_take)
  );

  always @(negedge clk) begin
    if (rx_valid) begin n_rx++; last_rx = rx_data; end
    if (rd_take) begin n_take++; rd_ptr = rd_ptr + 8'd1; end
    if (tmo_det) n_tmo++;
    if (stop_det) n_stop++;
    if (start_det) n_start++;
    if (addr_hit) n_hit++;
    if (watch_en && sda_oe) oe_seen = 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic do_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wq; m_scl = 1'b1; wq; r = sda_line; wq; m_scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(~mack, r);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic a, dk, r;
    logic [7:0] d;
    int rx0, st0, tk0;
    repeat (5) @(negedge clk);
    // R11: reset state
    chk("R11 sda_oe in reset", sda_oe, 0);
    chk("R11 dir_rd in reset", dir_rd, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 outputs after reset", {sda_oe, rx_valid, rd_take, addr_hit, tmo_det}, 0);

    // Table walk: write transfers, R2 R3 R4 R5
    for (int v = 0; v < 7; v++) begin
      rx0 = n_rx;
      busy = VEC[v][3];
      do_start();
      send_byte({VEC[v][18:12], 1'b0}, a);
      busy = VEC[v][2];
      send_byte(VEC[v][11:4], dk);
      busy = 1'b0;
      do_stop();
      wq;
      chk($sformatf("R2 addr ack vec%0d", v), a, VEC[v][1]);
      chk($sformatf("R4 data ack vec%0d", v), dk, VEC[v][0]);
      chk($sformatf("R5 rx count vec%0d", v), n_rx - rx0, VEC[v][1] & VEC[v][0]);
      if (VEC[v][1] & VEC[v][0]) chk($sformatf("R4 rx_data vec%0d", v), last_rx, VEC[v][11:4]);
    end
    chk("R1 start count", n_start, 7);
    chk("R1 stop count", n_stop, 7);
    chk("R2 addr_hit count", n_hit, 4);
    chk("R2 dir write", dir_rd, 0);

    // R6 R7: read two bytes, master ACK then NACK
    do_start();
    send_byte({DEV, 1'b1}, a);
    chk("R2 read addr ack", a, 1);
    chk("R2 dir read", dir_rd, 1);
    recv_byte(1'b1, d);
    chk("R6 first read byte", d, 8'hA5);
    recv_byte(1'b0, d);
    chk("R7 second read byte", d, 8'hA4);
    chk("R6 rd_take count", n_take, 2);
    watch_en = 1'b1;
    for (int i = 0; i < 9; i++) clk_bit(1'b1, r);
    watch_en = 1'b0;
    chk("R7 released after nack", oe_seen, 0);
    chk("R7 no take after nack", n_take, 2);
    do_stop();

    // R3: ignored after mismatch until STOP
    do_start();
    send_byte({7'h2A, 1'b1}, a);
    oe_seen = 1'b0; watch_en = 1'b1;
    recv_byte(1'b1, d);
    watch_en = 1'b0;
    chk("R3 mismatch nack", a, 0);
    chk("R3 no drive after mismatch", oe_seen, 0);
    chk("R3 no take after mismatch", n_take, 2);
    do_stop();

    // R8: repeated START mid-byte
    do_start();
    send_byte({DEV, 1'b0}, a);
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r);
    rx0 = n_rx; st0 = n_stop; tk0 = n_take;
    do_start();
    send_byte({DEV, 1'b1}, a);
    chk("R8 re-addressed ack", a, 1);
    recv_byte(1'b0, d);
    chk("R8 no stop pulse", n_stop - st0, 0);
    chk("R8 partial byte dropped", n_rx - rx0, 0);
    chk("R8 read after restart", d, 8'hA7);
    chk("R8 one take", n_take - tk0, 1);
    do_stop();

    // R9: timeout with SMBus mode on
    smbus_en = 1'b1;
    do_start();
    send_byte({DEV, 1'b0}, a);
    repeat (400) @(negedge clk);
    chk("R9 one timeout", n_tmo, 1);
    chk("R9 released", sda_oe, 0);
    rx0 = n_rx;
    send_byte(8'h99, dk);
    chk("R9 idle after timeout nack", dk, 0);
    chk("R9 no rx after timeout", n_rx - rx0, 0);
    do_stop();

    // R10: no timeout with SMBus mode off
    smbus_en = 1'b0;
    do_start();
    send_byte({DEV, 1'b0}, a);
    repeat (400) @(negedge clk);
    chk("R10 no timeout", n_tmo, 1);
    send_byte(8'h99, dk);
    chk("R10 transfer continues", dk, 1);
    chk("R10 rx_data", last_rx, 8'h99);
    do_stop();
    wq;
    finish_run();
  end
endmodule